// File: doc/BRIEF.md
# Wait-State Timing Unit

This block turns each memory access into a number of stall cycles. It keeps one 16-bit timing configuration word. It decodes the top four bits of a 28-bit access address into one of sixteen regions. From the region, the configuration word, the access width and a sequential flag, it forms the wait count for that access. The wait count is purely combinational, so the pipeline can read it in the same cycle that it presents the address.

The configuration word sets the timing of three external memory windows and of a byte-wide battery RAM region. Each window spans two neighbouring regions, a low one and a high one, and both halves always get the same timing. A fixed-speed on-board RAM region and the remaining internal regions do not depend on the configuration word. A 32-bit access is costed as two halfword accesses plus one turnaround cycle. The block also passes one configuration bit out as the prefetch-enable signal for an external prefetch unit.

Top module: `ws_timing_unit`

## Requirements
- R1: After reset the configuration word reads 0x0000 and prefetch_en is low. With that word, a 16-bit access costs the following (first/sequential): region 2 costs 2/2; regions 8 and 9 cost 4/2; regions 10 and 11 cost 4/4; regions 12 and 13 cost 4/8; region 14 costs 4/4; every other region costs 0/0.
- R2: When cfg_we is high on a rising edge, cfg_wdata is stored. From the next cycle on, cfg_rdata returns that value and the access timing uses it. With cfg_we low, the stored word does not change.
- R3: The first-access cost of a 16-bit access in a window region comes from a 2-bit code. Codes 0, 1, 2 and 3 give 4, 3, 2 and 8 cycles. Window 0 (regions 8 and 9) takes the code from bits [3:2], window 1 (regions 10 and 11) from bits [6:5], and window 2 (regions 12 and 13) from bits [9:8].
- R4: The sequential cost of a 16-bit access in a window region comes from one bit. Window 0 uses bit 4, and 0/1 gives 2/1 cycles. Window 1 uses bit 7, and 0/1 gives 4/1 cycles. Window 2 uses bit 10, and 0/1 gives 8/1 cycles.
- R5: The low and high regions of a window (8 and 9, 10 and 11, 12 and 13) give equal wait counts for every width, sequential flag and configuration.
- R6: Region 14 (battery RAM) uses the code in bits [1:0] with the R3 mapping, for both sequential and first accesses.
- R7: A 32-bit first access in regions 0 to 14 costs N + S + 1. Here N and S are that region's 16-bit first and sequential costs.
- R8: A 32-bit sequential access in regions 0 to 14 costs 2*S + 1.
- R9: Region 15 costs 0 cycles for every width, sequential flag and configuration.
- R10: prefetch_en follows bit 14 of the stored configuration word.
- R11: Region 2 and regions 0, 1 and 3 to 7 ignore the configuration word. Their 16-bit costs stay 2/2 and 0/0, and their 32-bit costs follow R7 and R8 (5/5 and 1/1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 16 | Configuration word to store |
| cfg_rdata | output | 16 | Stored configuration word |
| acc_addr | input | 28 | Access address; bits [27:24] select the region |
| acc_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| acc_seq | input | 1 | 1 = sequential access, 0 = first access |
| acc_wait | output | 5 | Wait cycles for the current access |
| prefetch_en | output | 1 | Prefetch enable from the configuration word |

## Verification
The bench builds the block with its default parameters: a 28-bit address, a 4-bit region index, a 16-bit configuration word and three windows. With a 4-bit region, the bench can sweep all sixteen regions, both widths and both sequential settings for each configuration word it loads. It loads the reset word, all-ones, alternating patterns and a word that sets the slowest code in every field. This reaches the largest cost, 17 cycles, and shows that a 5-bit wait output never wraps. A check placed in the same cycle as each write's effect shows that the new timing applies to the very next access.

// File: rtl/ws_pkg.sv
package ws_pkg;

    // Width of a wait count; the largest cost is 8 + 8 + 1 = 17.
    localparam int unsigned WS_W = 5;

    typedef logic [WS_W-1:0] ws_t;

    typedef struct packed {
        ws_t first;
        ws_t seq;
    } ws_pair_t;

    // Maps a 2-bit first-access code to a wait count.
    function automatic ws_t first_code_cost(input logic [1:0] code);
        ws_t cost;
        unique case (code)
            2'd0:    cost = ws_t'(4);
            2'd1:    cost = ws_t'(3);
            2'd2:    cost = ws_t'(2);
            default: cost = ws_t'(8);
        endcase
        return cost;
    endfunction

endpackage

// File: rtl/ws_cfg_reg.sv
module ws_cfg_reg #(
    parameter int unsigned CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg
);

    typedef struct packed {
        logic [CFG_W-1:0] word;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.word = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg = st_q.word;

    // A write lands one edge later.
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (cfg == $past(wdata)));

    // Without a write, the word holds.
    assert_word_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg));

endmodule

// File: rtl/ws_window_timing.sv
module ws_window_timing
    import ws_pkg::*;
#(
    parameter int unsigned WIN_IDX = 0
) (
    input  logic [1:0] first_code,
    input  logic       fast_seq,
    output ws_pair_t   cost
);

    // The slow sequential cost doubles from one window to the next: 2, 4, 8.
    localparam int unsigned SLOW_SEQ = 2 << WIN_IDX;

    ws_pair_t cost_d;

    always_comb begin
        cost_d.first = first_code_cost(first_code);
        cost_d.seq   = fast_seq ? ws_t'(1) : ws_t'(SLOW_SEQ);
    end

    assign cost = cost_d;

endmodule

// File: rtl/ws_access_cost.sv
module ws_access_cost
    import ws_pkg::*;
(
    input  ws_pair_t pair,
    input  logic     wide,
    input  logic     seq,
    input  logic     null_region,
    output ws_t      wait_cycles
);

    ws_t wait_d;

    always_comb begin
        if (null_region) begin
            wait_d = '0;
        end else if (!wide) begin
            wait_d = seq ? pair.seq : pair.first;
        end else if (seq) begin
            wait_d = (pair.seq << 1) + ws_t'(1);
        end else begin
            wait_d = pair.first + pair.seq + ws_t'(1);
        end
    end

    assign wait_cycles = wait_d;

endmodule

// File: rtl/ws_timing_unit.sv
module ws_timing_unit
    import ws_pkg::*;
#(
    parameter int unsigned ADDR_W       = 28,
    parameter int unsigned REGION_W     = 4,
    parameter int unsigned CFG_W        = 16,
    parameter int unsigned N_WIN        = 3,
    parameter int unsigned WIN_BASE_REG = 8,
    parameter int unsigned SRAM_REG     = 14,
    parameter int unsigned FAST_REG     = 2,
    parameter int unsigned FAST_WAIT    = 2,
    parameter int unsigned PF_BIT       = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_wide,
    input  logic              acc_seq,
    output logic [WS_W-1:0]   acc_wait,
    output logic              prefetch_en
);

    localparam int unsigned NULL_REG   = (1 << REGION_W) - 1;
    localparam int unsigned LOW_W      = ADDR_W - REGION_W;
    localparam int unsigned WIN_FIELD0 = 2;   // first window field starts above the RAM code
    localparam int unsigned WIN_STRIDE = 3;   // 2-bit code plus 1 sequential bit

    logic [CFG_W-1:0]    cfg_q;
    logic [REGION_W-1:0] region;
    logic                unused_low;
    ws_pair_t            win_cost [N_WIN];
    ws_pair_t            pair_d;
    logic                null_d;
    ws_t                 sram_cost;

    ws_cfg_reg #(.CFG_W(CFG_W)) cfg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg_q)
    );

    generate
        for (genvar w = 0; w < N_WIN; w++) begin : g_win
            localparam int unsigned LSB = WIN_FIELD0 + w * WIN_STRIDE;
            ws_window_timing #(.WIN_IDX(w)) win_i (
                .first_code (cfg_q[LSB+1:LSB]),
                .fast_seq   (cfg_q[LSB+2]),
                .cost       (win_cost[w])
            );
        end
    endgenerate

    assign region     = acc_addr[ADDR_W-1 -: REGION_W];
    assign unused_low = &{1'b0, acc_addr[LOW_W-1:0]};
    assign sram_cost  = first_code_cost(cfg_q[1:0]);

    always_comb begin
        pair_d = '0;
        null_d = (int'(region) == NULL_REG);
        if (int'(region) == SRAM_REG) begin
            pair_d.first = sram_cost;
            pair_d.seq   = sram_cost;
        end else if (int'(region) == FAST_REG) begin
            pair_d.first = ws_t'(FAST_WAIT);
            pair_d.seq   = ws_t'(FAST_WAIT);
        end
        for (int w = 0; w < N_WIN; w++) begin
            if ((int'(region) >> 1) == (WIN_BASE_REG >> 1) + w) begin
                pair_d = win_cost[w];
            end
        end
    end

    ws_access_cost cost_i (
        .pair        (pair_d),
        .wide        (acc_wide),
        .seq         (acc_seq),
        .null_region (null_d),
        .wait_cycles (acc_wait)
    );

    assign cfg_rdata   = cfg_q;
    assign prefetch_en = cfg_q[PF_BIT];

    assert_null_region_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr[ADDR_W-1 -: REGION_W] == REGION_W'(NULL_REG)) |-> (acc_wait == '0));

    assert_wide_seq_odd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wide && acc_seq && acc_addr[ADDR_W-1 -: REGION_W] != REGION_W'(NULL_REG))
            |-> acc_wait[0]);

    assert_wide_first_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wide && !acc_seq && acc_addr[ADDR_W-1 -: REGION_W] != REGION_W'(NULL_REG))
            |-> (acc_wait != '0));

    assert_window_first_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_wide && !acc_seq && acc_addr[ADDR_W-1 -: REGION_W] >= REGION_W'(WIN_BASE_REG)
         && acc_addr[ADDR_W-1 -: REGION_W] < REGION_W'(WIN_BASE_REG + 2 * N_WIN))
            |-> (acc_wait inside {ws_t'(2), ws_t'(3), ws_t'(4), ws_t'(8)}));

endmodule

// File: tb/ws_timing_unit_tb_top.sv
module ws_timing_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [27:0] acc_addr = '0;
    logic        acc_wide = 1'b0;
    logic        acc_seq = 1'b0;
    logic [4:0]  acc_wait;
    logic        prefetch_en;

    always #10 clk = ~clk;   // 50 MHz

    ws_timing_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .acc_addr    (acc_addr),
        .acc_wide    (acc_wide),
        .acc_seq     (acc_seq),
        .acc_wait    (acc_wait),
        .prefetch_en (prefetch_en)
    );

    typedef struct {
        int          exp_wait;
        logic [15:0] exp_cfg;
        bit          exp_pf;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    int          compared = 0;
    int          mismatched = 0;
    bit          done = 1'b0;
    logic [15:0] cfg_m = '0;
    int          addr_salt = 0;

    function automatic int first_cost(input logic [1:0] code);
        case (code)
            2'd0: return 4;
            2'd1: return 3;
            2'd2: return 2;
            default: return 8;
        endcase
    endfunction

    // Expected cost from the requirement tables (R1, R3, R4, R6, R7, R8, R9, R11).
    function automatic int exp_cost(input logic [15:0] c, input int r, input bit w, input bit s);
        int n = 0;
        int q = 0;
        case (r)
            2:      begin n = 2; q = 2; end
            8, 9:   begin n = first_cost(c[3:2]); q = c[4]  ? 1 : 2; end
            10, 11: begin n = first_cost(c[6:5]); q = c[7]  ? 1 : 4; end
            12, 13: begin n = first_cost(c[9:8]); q = c[10] ? 1 : 8; end
            14:     begin n = first_cost(c[1:0]); q = n; end
            15:     return 0;
            default: begin n = 0; q = 0; end
        endcase
        if (!w) return s ? q : n;
        return s ? (2 * q + 1) : (n + q + 1);
    endfunction

    function automatic string tag_of(input bit reset_cfg, input int r, input bit w, input bit s);
        if (r == 15) return "R9";
        if (reset_cfg && !w) return "R1";
        if (w) return s ? "R8" : "R7";
        if (r == 14) return "R6";
        if (r < 8) return "R11";
        if (r % 2 == 1) return "R5";
        return s ? "R4" : "R3";
    endfunction

    task automatic drive_now(input int r, input bit w, input bit s, input string tag);
        item_t it;
        addr_salt = addr_salt + 24'h01_3579;
        acc_addr  = {4'(r), 24'(addr_salt)};
        acc_wide  = w;
        acc_seq   = s;
        it.exp_wait = exp_cost(cfg_m, r, w, s);
        it.exp_cfg  = cfg_m;
        it.exp_pf   = cfg_m[14];
        it.tag      = tag;
        sb_q.push_back(it);
    endtask

    task automatic access(input int r, input bit w, input bit s, input string tag);
        @(posedge clk);
        #2;
        drive_now(r, w, s, tag);
    endtask

    task automatic write_cfg(input logic [15:0] v);
        @(posedge clk);
        #2;
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(posedge clk);
        #2;
        cfg_we    = 1'b0;
        cfg_wdata = ~v;   // a changed data bus must not reach the word (R2)
        cfg_m     = v;
        drive_now(10, 1'b0, 1'b0, "R2");   // new timing on the very next access
    endtask

    task automatic sweep(input bit reset_cfg);
        for (int r = 0; r < 16; r++) begin
            for (int w = 0; w < 2; w++) begin
                for (int s = 0; s < 2; s++) begin
                    access(r, w[0], s[0], tag_of(reset_cfg, r, w[0], s[0]));
                end
            end
        end
    endtask

    // Monitor: pops one expected item per cycle, away from the clock edge.
    initial begin
        forever begin
            @(posedge clk);
            #12;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                compared++;
                if (int'(acc_wait) != it.exp_wait) begin
                    mismatched++;
                    $display("FAIL %s: acc_wait actual %0d expected %0d", it.tag, acc_wait, it.exp_wait);
                end
                compared++;
                if (cfg_rdata !== it.exp_cfg) begin
                    mismatched++;
                    $display("FAIL R2: cfg_rdata actual %h expected %h", cfg_rdata, it.exp_cfg);
                end
                compared++;
                if (prefetch_en !== it.exp_pf) begin
                    mismatched++;
                    $display("FAIL R10: prefetch_en actual %0b expected %0b", prefetch_en, it.exp_pf);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout after 100000 cycles expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        // R1: reset word and reset timing table
        drive_now(0, 1'b0, 1'b0, "R1");
        sweep(1'b1);
        // R10: prefetch bit only
        write_cfg(16'h4000);
        access(12, 1'b0, 1'b1, "R10");
        // R3/R4/R5/R6/R7/R8/R11 under several field patterns
        write_cfg(16'h0555);
        sweep(1'b0);
        write_cfg(16'h0AAA);
        sweep(1'b0);
        write_cfg(16'h036F);   // slowest codes everywhere, largest costs
        sweep(1'b0);
        write_cfg(16'hFFFF);
        sweep(1'b0);
        write_cfg(16'h5A26);
        sweep(1'b0);
        write_cfg(16'h0000);
        access(13, 1'b1, 1'b0, "R2");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule